// File: doc/BRIEF.md
# Modulo Timer with One Capture/Compare Channel

This block is a 16-bit up-counter that runs from zero to a programmed modulo value and then returns to zero. It is paced by a tick enable input, so an external prescaler decides how fast it runs. Software can stop the counter or clear it. An overflow flag is raised on every return to zero.

A single channel sits beside the counter. In capture mode it watches a synchronized input pin and stores the counter value on the selected edge. In compare mode it toggles an output pin when the counter equals the channel value. Both channel events set one shared channel flag. Each flag has its own enable, and one interrupt line carries the OR of the two enabled flags.

Software sees four 16-bit registers through a simple read/write strobe interface. A flag is cleared in two steps: first read its register while the flag is set, then write a 0 to the flag bit.

Top module: `mod_timer`

## Requirements
- R1: After reset the counter reads 0 and the modulo register (address 1) reads 0xFFFF. The counter increments only on clock edges where `tick_i` is high. On an advancing edge where the counter already equals the modulo value, it returns to 0 instead of incrementing.
- R2: The overflow flag (status register, address 0, bit 7) is set on the same edge on which the counter returns to 0 by way of a modulo match.
- R3: A flag (bit 7 of address 0 or address 2) is cleared only by a write of 0 to that bit, and only after a read of the same register while the flag was set. A write without that prior read leaves the flag as it was. A flag-setting event on the same edge as the clearing write wins, and the flag stays set.
- R4: `irq_o` is high exactly when (overflow flag AND overflow enable, address 0 bit 6) OR (channel flag AND channel enable, address 2 bit 6).
- R5: In capture mode (address 2 bit 4 = 0), the edge select field (address 2 bits 1:0) chooses the edges that act: 01 rising, 10 falling, 11 both. An edge of `cap_pin_i` that passes a two-flop synchronizer stores the counter value into the channel register (address 3) and sets the channel flag. The value stored is the counter value two clock edges after the edge that first samples the new pin level.
- R6: In compare mode (address 2 bit 4 = 1), an advancing edge where the counter equals the channel register toggles `chan_o` and sets the channel flag.
- R7: Writing address 0 with bit 5 set stops the counter, so its value holds. Writing address 0 with bit 4 set clears the counter to 0 on that edge. Bit 4 reads back as 0.
- R8: In capture mode `chan_o` never changes. With edge select 00, pin edges store nothing and set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable (prescaler pulse) |
| cap_pin_i | input | 1 | Asynchronous capture input |
| addr_i | input | 2 | Register address: 0 status, 1 modulo, 2 channel control, 3 channel value |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (arms flag clear) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| count_o | output | 16 | Current counter value |
| chan_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same edge: the software write that clears a flag, and a new event that sets the same flag. This happens for a modulo wrap and for a channel event. The bench arms the overflow clear and then waits until the counter equals the modulo value with the tick high. It issues the clearing write in exactly that cycle, so the write edge is the wrap edge. A behavioural model gives the event priority. The bench compares the flag, interrupt, count and read data against that model on every clock, and it reads the flag back directly afterwards.

// File: rtl/mod_timer_pkg.sv
`timescale 1ns/1ps
package mod_timer_pkg;
  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MOD  = 2'd1,
    A_CHC  = 2'd2,
    A_CHV  = 2'd3
  } reg_addr_e;

  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int STOP_B = 5;
  localparam int CLR_B  = 4;
  localparam int MODE_B = 4;
endpackage

// File: rtl/mt_counter.sv
`timescale 1ns/1ps
module mt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         stop_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         adv_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign adv_o  = tick_i & ~stop_i & ~clr_i;
  assign wrap_o = adv_o & (cnt_q == mod_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_o) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !wrap_o) |=> cnt_o == $past(cnt_o) + 1'b1);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
  // R7
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || stop_i) && !clr_i |=> $stable(cnt_o));
  // R7
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/mt_channel.sv
`timescale 1ns/1ps
module mt_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  logic         cmp_mode_i,
  input  logic [1:0]   edge_sel_i,
  input  logic         adv_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_val_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic         event_o,
  output logic         out_o
);
  logic [2:0]   sync_q;
  logic [W-1:0] val_q;
  logic         out_q;
  logic         rise, fall, cap, hit;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign fall    = ~sync_q[1] & sync_q[2];
  assign cap     = ~cmp_mode_i & ((edge_sel_i[0] & rise) | (edge_sel_i[1] & fall));
  assign hit     = cmp_mode_i & adv_i & (cnt_i == val_q);
  assign event_o = cap | hit;
  assign val_o   = val_q;
  assign out_o   = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      val_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], pin_i};
      if (cap)           val_q <= cnt_i;  // capture beats software write
      else if (wr_val_i) val_q <= wdata_i;
      if (hit)           out_q <= ~out_q;
    end
  end

  // R5
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !cmp_mode_i) |=> val_o == $past(cnt_i));
  // R6
  cmp_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && cmp_mode_i) |=> out_o != $past(out_o));
  // R8
  cap_no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_mode_i |=> $stable(out_o));
endmodule

// File: rtl/mod_timer.sv
`timescale 1ns/1ps
module mod_timer
  import mod_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cap_pin_i,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] count_o,
  output logic         chan_o,
  output logic         irq_o
);
  logic         wr_stat, wr_mod, wr_chc, wr_chv, rd_stat, rd_chc;
  logic         ovf_f, ovf_ie, stop_q, arm_ovf;
  logic         ch_f, ch_ie, mode_q, arm_ch;
  logic [1:0]   edge_q;
  logic [W-1:0] mod_q, chv;
  logic         adv, wrap, ch_evt, ovf_clr, ch_clr;

  assign wr_stat = wr_i && addr_i == A_STAT;
  assign wr_mod  = wr_i && addr_i == A_MOD;
  assign wr_chc  = wr_i && addr_i == A_CHC;
  assign wr_chv  = wr_i && addr_i == A_CHV;
  assign rd_stat = rd_i && addr_i == A_STAT;
  assign rd_chc  = rd_i && addr_i == A_CHC;
  assign ovf_clr = wr_stat && arm_ovf && !wdata_i[FLAG_B];
  assign ch_clr  = wr_chc && arm_ch && !wdata_i[FLAG_B];

  mt_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .stop_i (stop_q),
    .clr_i  (wr_stat && wdata_i[CLR_B]),
    .mod_i  (mod_q),
    .cnt_o  (count_o),
    .adv_o  (adv),
    .wrap_o (wrap)
  );

  mt_channel #(.W(W)) u_ch (
    .clk_i, .rst_ni,
    .pin_i      (cap_pin_i),
    .cmp_mode_i (mode_q),
    .edge_sel_i (edge_q),
    .adv_i      (adv),
    .cnt_i      (count_o),
    .wr_val_i   (wr_chv),
    .wdata_i    (wdata_i),
    .val_o      (chv),
    .event_o    (ch_evt),
    .out_o      (chan_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_f <= 1'b0; ovf_ie <= 1'b0; stop_q <= 1'b0; arm_ovf <= 1'b0;
      ch_f  <= 1'b0; ch_ie  <= 1'b0; mode_q <= 1'b0; arm_ch  <= 1'b0;
      edge_q <= '0;
      mod_q  <= '1;
    end else begin
      if (wrap)         ovf_f <= 1'b1;
      else if (ovf_clr) ovf_f <= 1'b0;
      if (ch_evt)       ch_f <= 1'b1;
      else if (ch_clr)  ch_f <= 1'b0;

      if (rd_stat && ovf_f) arm_ovf <= 1'b1;
      else if (wr_stat)     arm_ovf <= 1'b0;
      if (rd_chc && ch_f)   arm_ch <= 1'b1;
      else if (wr_chc)      arm_ch <= 1'b0;

      if (wr_stat) begin
        ovf_ie <= wdata_i[IE_B];
        stop_q <= wdata_i[STOP_B];
      end
      if (wr_chc) begin
        ch_ie  <= wdata_i[IE_B];
        mode_q <= wdata_i[MODE_B];
        edge_q <= wdata_i[1:0];
      end
      if (wr_mod) mod_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STAT: begin
        rdata_o[FLAG_B] = ovf_f;
        rdata_o[IE_B]   = ovf_ie;
        rdata_o[STOP_B] = stop_q;
      end
      A_MOD: rdata_o = mod_q;
      A_CHC: begin
        rdata_o[FLAG_B] = ch_f;
        rdata_o[IE_B]   = ch_ie;
        rdata_o[MODE_B] = mode_q;
        rdata_o[1:0]    = edge_q;
      end
      default: rdata_o = chv;
    endcase
  end

  assign irq_o = (ovf_f & ovf_ie) | (ch_f & ch_ie);

  // R2
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_f);
  // R3
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_f && !(wr_i && addr_i == A_STAT)) |=> ovf_f);
  // R3
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_f && !(wr_i && addr_i == A_CHC)) |=> ch_f);
  // R3
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_f) |-> $past(wr_i) && $past(addr_i) == A_STAT && !$past(wdata_i[FLAG_B]));
endmodule

// File: tb/mod_timer_test.sv
`timescale 1ns/1ps
module mod_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, pin = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count;
  logic        chan, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mod_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_pin_i(pin),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .count_o(count), .chan_o(chan), .irq_o(irq)
  );

  // behavioural reference model
  int m_cnt, m_mod, m_chv;
  bit m_ovf, m_ovie, m_stop, m_arm_o, m_chf, m_chie, m_mode, m_arm_c, m_out;
  bit [1:0] m_edge;
  bit pq[$];

  function automatic int mread(int a);
    case (a)
      0: return (m_ovf << 7) | (m_ovie << 6) | (m_stop << 5);
      1: return m_mod;
      2: return (m_chf << 7) | (m_chie << 6) | (m_mode << 4) | m_edge;
      default: return m_chv;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit clr, adv, wrap, rise, fall, cap, hit;
    int n_cnt, n_chv;
    bit n_ovf, n_chf;
    if (!rst_n) begin
      m_cnt = 0; m_mod = 16'hFFFF; m_chv = 0;
      m_ovf = 0; m_ovie = 0; m_stop = 0; m_arm_o = 0;
      m_chf = 0; m_chie = 0; m_mode = 0; m_arm_c = 0; m_out = 0; m_edge = 0;
      pq = '{0, 0, 0};
    end else begin
      clr  = wr && addr == 0 && wdata[4];
      adv  = tick && !m_stop && !clr;
      wrap = adv && m_cnt == m_mod;
      rise = pq[1] && !pq[0];
      fall = !pq[1] && pq[0];
      cap  = !m_mode && ((m_edge[0] && rise) || (m_edge[1] && fall));
      hit  = m_mode && adv && m_cnt == m_chv;
      n_cnt = clr ? 0 : (adv ? (wrap ? 0 : m_cnt + 1) : m_cnt);
      n_chv = cap ? m_cnt : ((wr && addr == 3) ? int'(wdata) : m_chv);
      n_ovf = wrap ? 1'b1 : ((wr && addr == 0 && m_arm_o && !wdata[7]) ? 1'b0 : m_ovf);
      n_chf = (cap || hit) ? 1'b1 : ((wr && addr == 2 && m_arm_c && !wdata[7]) ? 1'b0 : m_chf);
      if (rd && addr == 0 && m_ovf) m_arm_o = 1; else if (wr && addr == 0) m_arm_o = 0;
      if (rd && addr == 2 && m_chf) m_arm_c = 1; else if (wr && addr == 2) m_arm_c = 0;
      if (wr && addr == 0) begin m_ovie = wdata[6]; m_stop = wdata[5]; end
      if (wr && addr == 2) begin m_chie = wdata[6]; m_mode = wdata[4]; m_edge = wdata[1:0]; end
      if (wr && addr == 1) m_mod = wdata;
      if (hit) m_out = !m_out;
      m_cnt = n_cnt; m_chv = n_chv; m_ovf = n_ovf; m_chf = n_chf;
      pq.push_back(pin);
      void'(pq.pop_front());
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 count", int'(count), m_cnt);
      chk("R6 chan_o", int'(chan), int'(m_out));
      chk("R4 irq_o", int'(irq), int'((m_ovf && m_ovie) || (m_chf && m_chie)));
      chk("R2/R3/R5 rdata", int'(rdata), mread(int'(addr)));
    end
  end

  task automatic wreg(int a, int d);
    addr = 2'(a); wdata = 16'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(int a, output int v);
    addr = 2'(a); rd = 1'b1; #1 v = int'(rdata);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_count(int c);
    int guard = 0;
    while (int'(count) != c && guard < 70000) begin @(negedge clk); guard++; end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int v, c0;
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", int'(count), 0);
    chk("R4 reset irq", int'(irq), 0);
    rreg(1, v); chk("R1 reset modulo", v, 16'hFFFF);

    // wrap at modulo 5
    wreg(1, 5);
    tick = 1'b1;
    wait_count(5); @(negedge clk);
    chk("R1 wrap to zero", int'(count), 0);
    // stop without prior read: flag must survive
    wreg(0, 16'h0020);
    c0 = int'(count);
    repeat (5) @(negedge clk);
    chk("R7 stop holds", int'(count), c0);
    rreg(0, v); chk("R3 no-read write keeps flag", (v >> 7) & 1, 1);
    chk("R2 flag set by wrap", (v >> 7) & 1, 1);
    wreg(0, 16'h0020);
    rreg(0, v); chk("R3 armed clear", (v >> 7) & 1, 0);
    wreg(0, 16'h0030);
    chk("R7 clear bit zeroes", int'(count), 0);
    rreg(0, v); chk("R7 clear bit reads 0", (v >> 4) & 1, 0);

    // overflow interrupt and clear/event collision
    wreg(0, 16'h0040);
    wait_count(5); @(negedge clk);
    chk("R4 overflow irq", int'(irq), 1);
    rreg(0, v);
    wait_count(5);
    wreg(0, 16'h0040);  // clear write on the wrap edge
    rreg(0, v); chk("R3 event beats clear", (v >> 7) & 1, 1);
    wreg(0, 16'h0040);
    rreg(0, v); chk("R3 clear after read", (v >> 7) & 1, 0);
    wreg(0, 16'h0000);

    // tick gating
    for (int i = 0; i < 120; i++) begin tick = 1'($urandom_range(0, 1)); @(negedge clk); end
    tick = 1'b1;

    // compare mode
    wreg(1, 19); wreg(3, 7); wreg(2, 16'h0050);
    wait_count(7); c0 = int'(chan); @(negedge clk);
    chk("R6 compare toggles", int'(chan), c0 ^ 1);
    rreg(2, v); chk("R6 channel flag", (v >> 7) & 1, 1);
    chk("R4 channel irq", int'(irq), 1);
    repeat (60) @(negedge clk);

    // capture mode, rising edge
    wreg(2, 16'h0001); rreg(2, v); wreg(2, 16'h0001);
    wait_count(3);
    c0 = int'(count); pin = 1'b1;
    repeat (4) @(negedge clk);
    rreg(3, v); chk("R5 rising capture value", v, c0 + 2);
    rreg(2, v); chk("R5 capture flag", (v >> 7) & 1, 1);
    wreg(2, 16'h0001);
    c0 = v; rreg(3, c0);
    pin = 1'b0; repeat (5) @(negedge clk);
    rreg(3, v); chk("R5 falling ignored on rising select", v, c0);
    // edge select 00
    wreg(2, 16'h0000);
    c0 = int'(chan);
    for (int i = 0; i < 6; i++) begin pin = ~pin; repeat (4) @(negedge clk); end
    rreg(2, v); chk("R8 select 00 no flag", (v >> 7) & 1, 0);
    chk("R8 chan_o static in capture", int'(chan), c0);
    // both edges
    wreg(2, 16'h0043);
    wait_count(2);
    c0 = int'(count); pin = ~pin;
    repeat (4) @(negedge clk);
    rreg(3, v); chk("R5 both-edge capture value", v, c0 + 2);

    // random mix
    for (int i = 0; i < 400; i++) begin
      tick = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      case ($urandom_range(0, 9))
        0: rreg($urandom_range(0, 3), v);
        1: wreg(2, ($urandom_range(0, 1) << 6) | ($urandom_range(0, 1) << 4) | $urandom_range(0, 3));
        2: wreg(0, $urandom_range(0, 1) << 6);
        3: wreg(3, $urandom_range(0, 19));
        default: @(negedge clk);
      endcase
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule